// File: doc/BRIEF.md
# Harmonic Number Ramp Controller

This block sets the harmonic number that scales the phase increment of a numerically controlled oscillator. It does not switch the harmonic in one step. It moves it from its present value to a programmed destination along a straight line, over a number of clock ticks that software chooses. Software writes the destination harmonic and the ramp length through a small write-only register port. It then writes a start bit, and the block does the rest alone.

The block outputs the current harmonic and a busy flag on every clock. A simple phase accumulator is included as the downstream consumer. On each clock it adds the revolution-rate increment multiplied by the current harmonic. This makes the effect of the ramp on the oscillator phase visible at a port.

At start, the block divides the harmonic difference by the tick count to get a signed slope with 16 fractional bits. It adds that slope to a fractional accumulator on every clock and outputs the accumulator's integer part. When the tick count runs out, the output is set exactly to the destination, which removes any rounding error left over from the slope.

Top module: `hramp_ctrl`

## Requirements
- R1: While synchronous reset is high, and on the first clock after it, the harmonic output is 1, busy is 0 and the phase output is 0. The stored destination resets to 1 and the stored length resets to 0.
- R2: A write with `wr_addr` = 0 stores `wr_data[HW-1:0]` as the destination harmonic. A write with `wr_addr` = 1 stores `wr_data[TW-1:0]` as the ramp length. A write with `wr_addr` = 2 and `wr_data[0]` = 1 is a start request.
- R3: A start request accepted while idle with length L >= 2 raises busy on the next clock. On that clock the harmonic still shows the value it had when the request was accepted, called the start value S. Busy then stays high for exactly L clocks.
- R4: k clocks after busy rises, for 1 <= k <= L-1, the harmonic equals floor(S + k*D). D is (T - S) * 65536 / L, with the division truncated toward zero, divided again by 65536. T is the destination.
- R5: L clocks after busy rises, the harmonic equals T exactly and busy is 0.
- R6: During a ramp the harmonic never moves away from T. It never decreases on an upward ramp and never increases on a downward ramp.
- R7: A start request accepted with L = 0 or L = 1 puts T on the harmonic output on the next clock, and busy stays 0.
- R8: A start request made while busy has no effect: the running ramp keeps its slope and its end time.
- R9: On every clock outside reset, the phase output advances by `rev_inc` times the harmonic, modulo 2^PHW.
- R10: Writes to the destination or length registers while busy are discarded. A later zero-length start then loads the earlier destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 destination, 1 length, 2 control |
| wr_data | input | DW | Write data |
| rev_inc | input | PHW | Revolution-rate phase increment |
| harm | output | HW | Current harmonic number |
| busy | output | 1 | High while a ramp is in progress |
| phase | output | PHW | Oscillator phase accumulator |

## Verification
The bench builds the block with a 16-bit harmonic, a 12-bit length field, 16 fractional bits and a 32-bit phase. With these values a full-scale ramp from 20 up to 65535 fits in a short run and still needs a slope whose fractional part is far from zero. The 12-bit length keeps every ramp, including the longest one (1000 ticks), within a few thousand clocks. Ramps are run in both directions, with lengths 0, 1 and 2, with odd lengths that leave rounding residue, and with a destination equal to the start value. A behavioural model checks each one clock by clock, while control writes and start requests are made in the middle of ramps.

// File: rtl/hramp_pkg.sv
package hramp_pkg;

    typedef enum logic [1:0] {
        REG_DEST = 2'd0,
        REG_LEN  = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } hr_addr_e;

    localparam int unsigned CTRL_GO_BIT = 0;

endpackage

// File: rtl/hramp_regs.sv
module hramp_regs
    import hramp_pkg::*;
#(
    parameter int unsigned HW = 16,
    parameter int unsigned TW = 16,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    output logic [HW-1:0] dest,
    output logic [TW-1:0] len,
    output logic          go
);

    typedef struct packed {
        logic [HW-1:0] dest;
        logic [TW-1:0] len;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        go  = 1'b0;
        if (wr_en && !busy) begin
            unique case (hr_addr_e'(wr_addr))
                REG_DEST: r_d.dest = wr_data[HW-1:0];
                REG_LEN:  r_d.len  = wr_data[TW-1:0];
                REG_CTRL: go       = wr_data[CTRL_GO_BIT];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.dest <= HW'(1);
            r_q.len  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dest = r_q.dest;
    assign len  = r_q.len;

endmodule

// File: rtl/hramp_slope.sv
module hramp_slope #(
    parameter int unsigned HW   = 16,
    parameter int unsigned TW   = 16,
    parameter int unsigned FRAC = 16,
    localparam int unsigned SW  = HW + FRAC + 2
) (
    input  logic [HW-1:0]        from_h,
    input  logic [HW-1:0]        to_h,
    input  logic [TW-1:0]        ticks,
    output logic signed [SW-1:0] slope
);

    logic signed [SW-1:0] diff_w;
    logic signed [SW-1:0] num_w;
    logic signed [SW-1:0] den_w;

    always_comb begin
        diff_w = $signed({{(SW-HW){1'b0}}, to_h}) - $signed({{(SW-HW){1'b0}}, from_h});
        num_w  = diff_w <<< FRAC;
        if (ticks < TW'(2)) begin
            den_w = SW'(1);
        end else begin
            den_w = $signed({{(SW-TW){1'b0}}, ticks});
        end
        slope = num_w / den_w;
    end

endmodule

// File: rtl/hramp_core.sv
module hramp_core #(
    parameter int unsigned HW   = 16,
    parameter int unsigned TW   = 16,
    parameter int unsigned FRAC = 16,
    localparam int unsigned SW  = HW + FRAC + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [HW-1:0]        dest,
    input  logic [TW-1:0]        len,
    input  logic signed [SW-1:0] slope,
    output logic [HW-1:0]        harm,
    output logic                 busy,
    output logic                 up
);

    typedef struct packed {
        logic [HW-1:0]        harm;
        logic                 busy;
        logic                 up;
        logic [HW-1:0]        dest;
        logic [TW-1:0]        left;
        logic signed [SW-1:0] acc;
        logic signed [SW-1:0] slope;
    } core_t;

    core_t c_d, c_q;
    logic signed [SW-1:0] acc_nx;

    always_comb begin
        c_d    = c_q;
        acc_nx = c_q.acc + c_q.slope;
        if (c_q.busy) begin
            if (c_q.left == '0) begin
                c_d.harm = c_q.dest;
                c_d.busy = 1'b0;
            end else begin
                c_d.acc  = acc_nx;
                c_d.left = c_q.left - TW'(1);
                c_d.harm = acc_nx[FRAC+HW-1:FRAC];
            end
        end else if (go) begin
            c_d.dest = dest;
            c_d.up   = (dest >= c_q.harm);
            if (len < TW'(2)) begin
                c_d.harm = dest;
            end else begin
                c_d.busy  = 1'b1;
                c_d.left  = len - TW'(1);
                c_d.acc   = $signed({{(SW-HW){1'b0}}, c_q.harm}) <<< FRAC;
                c_d.slope = slope;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.harm  <= HW'(1);
            c_q.busy  <= 1'b0;
            c_q.up    <= 1'b1;
            c_q.dest  <= HW'(1);
            c_q.left  <= '0;
            c_q.acc   <= '0;
            c_q.slope <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign harm = c_q.harm;
    assign busy = c_q.busy;
    assign up   = c_q.up;

endmodule

// File: rtl/hramp_nco.sv
module hramp_nco #(
    parameter int unsigned HW  = 16,
    parameter int unsigned PHW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [PHW-1:0] rev_inc,
    input  logic [HW-1:0]  harm,
    output logic [PHW-1:0] phase
);

    logic [PHW+HW-1:0] prod_w;
    logic [PHW-1:0]    ph_d, ph_q;

    always_comb begin
        prod_w = (PHW+HW)'(rev_inc) * (PHW+HW)'(harm);
        ph_d   = ph_q + prod_w[PHW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_d;
    end

    assign phase = ph_q;

endmodule

// File: rtl/hramp_ctrl.sv
module hramp_ctrl #(
    parameter int unsigned HW   = 16,
    parameter int unsigned TW   = 16,
    parameter int unsigned FRAC = 16,
    parameter int unsigned PHW  = 32,
    parameter int unsigned DW   = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [PHW-1:0] rev_inc,
    output logic [HW-1:0]  harm,
    output logic           busy,
    output logic [PHW-1:0] phase
);

    localparam int unsigned SW = HW + FRAC + 2;

    logic [HW-1:0]        dest_w;
    logic [TW-1:0]        len_w;
    logic                 go_w;
    logic signed [SW-1:0] slope_w;
    logic                 up_w;

    hramp_regs #(.HW(HW), .TW(TW), .DW(DW)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .dest    (dest_w),
        .len     (len_w),
        .go      (go_w)
    );

    hramp_slope #(.HW(HW), .TW(TW), .FRAC(FRAC)) slope_i (
        .from_h (harm),
        .to_h   (dest_w),
        .ticks  (len_w),
        .slope  (slope_w)
    );

    hramp_core #(.HW(HW), .TW(TW), .FRAC(FRAC)) core_i (
        .clk   (clk),
        .rst   (rst),
        .go    (go_w),
        .dest  (dest_w),
        .len   (len_w),
        .slope (slope_w),
        .harm  (harm),
        .busy  (busy),
        .up    (up_w)
    );

    hramp_nco #(.HW(HW), .PHW(PHW)) nco_i (
        .clk     (clk),
        .rst     (rst),
        .rev_inc (rev_inc),
        .harm    (harm),
        .phase   (phase)
    );

endmodule

// File: rtl/hramp_chk.sv
module hramp_chk #(
    parameter int unsigned HW  = 16,
    parameter int unsigned TW  = 16,
    parameter int unsigned PHW = 32,
    parameter int unsigned DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [1:0]     wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic [PHW-1:0] rev_inc,
    input logic [HW-1:0]  harm,
    input logic           busy,
    input logic [PHW-1:0] phase,
    input logic [HW-1:0]  dest,
    input logic [TW-1:0]  len,
    input logic           up
);

    logic start_ok;
    logic [PHW+HW-1:0] prod_c;

    assign start_ok = wr_en && !busy && (wr_addr == 2'd2) && wr_data[0];
    assign prod_c   = (PHW+HW)'(rev_inc) * (PHW+HW)'(harm);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (harm == HW'(1) && !busy && phase == '0)); // R1

    AST_LONG_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_ok && len >= TW'(2)) |=> (busy && $stable(harm))); // R3

    AST_LAND_ON_DEST: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (harm == dest)); // R5

    AST_RAMP_UP_MONO: assert property (@(posedge clk) disable iff (rst)
        (busy && up) |=> (harm >= $past(harm))); // R6

    AST_RAMP_DN_MONO: assert property (@(posedge clk) disable iff (rst)
        (busy && !up) |=> (harm <= $past(harm))); // R6

    AST_SHORT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (start_ok && len < TW'(2)) |=> (!busy && harm == $past(dest))); // R7

    AST_BUSY_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> ($stable(dest) && $stable(len))); // R10

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase == PHW'($past(phase) + $past(prod_c[PHW-1:0])))); // R9

endmodule

bind hramp_ctrl hramp_chk #(.HW(HW), .TW(TW), .PHW(PHW), .DW(DW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rev_inc (rev_inc),
    .harm    (harm),
    .busy    (busy),
    .phase   (phase),
    .dest    (dest_w),
    .len     (len_w),
    .up      (up_w)
);

// File: tb/hramp_ctrl_tb_top.sv
`timescale 1ns/1ps
module hramp_ctrl_tb_top;

    localparam int unsigned HW   = 16;
    localparam int unsigned TW   = 12;
    localparam int unsigned FRAC = 16;
    localparam int unsigned PHW  = 32;
    localparam int unsigned DW   = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [PHW-1:0] rev_inc = 32'h0001_0003;
    logic [HW-1:0]  harm;
    logic           busy;
    logic [PHW-1:0] phase;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hramp_ctrl #(.HW(HW), .TW(TW), .FRAC(FRAC), .PHW(PHW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rev_inc(rev_inc),
        .harm(harm), .busy(busy), .phase(phase)
    );

    // behavioural reference model
    longint m_harm = 1, m_dest = 1, m_len = 0, m_acc = 0, m_slope = 0, m_left = 0;
    longint m_phase = 0, m_tgt_run = 1;
    bit     m_busy = 1'b0;

    always @(posedge clk) begin
        bit old_busy;
        old_busy = m_busy;
        if (rst) begin
            m_harm = 1; m_busy = 0; m_dest = 1; m_len = 0; m_phase = 0;
        end else begin
            m_phase = (m_phase + longint'(rev_inc) * m_harm) & 64'hFFFF_FFFF;
            if (m_busy) begin
                if (m_left == 0) begin
                    m_harm = m_tgt_run; m_busy = 0;
                end else begin
                    m_acc  = m_acc + m_slope;
                    m_left = m_left - 1;
                    m_harm = m_acc >>> 16;
                end
            end else if (wr_en && wr_addr == 2'd2 && wr_data[0]) begin
                m_tgt_run = m_dest;
                if (m_len < 2) m_harm = m_dest;
                else begin
                    m_busy  = 1;
                    m_acc   = m_harm <<< 16;
                    m_slope = ((m_dest - m_harm) * 65536) / m_len;
                    m_left  = m_len - 1;
                end
            end
            if (wr_en && !old_busy) begin
                if (wr_addr == 2'd0) m_dest = longint'(wr_data[HW-1:0]);
                if (wr_addr == 2'd1) m_len  = longint'(wr_data[TW-1:0]);
            end
        end
    end

    // per-clock comparison (R4, R9 and R1 during reset)
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (longint'(harm) != m_harm || busy != m_busy) begin
                errors++;
                $display("FAIL R4 harm/busy actual %0d/%0b expected %0d/%0b at %0t",
                         harm, busy, m_harm, m_busy, $time);
            end
            checks++;
            if (longint'(phase) != m_phase) begin
                errors++;
                $display("FAIL R9 phase actual %0h expected %0h at %0t", phase, m_phase, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // full ramp with landing and monotonic checks (R2, R3, R5, R6)
    task automatic ramp(input int dst, input int l);
        int s;
        int prev;
        wr(2'd0, DW'(dst));
        wr(2'd1, DW'(l));
        s = int'(harm);
        wr(2'd2, 32'h1);
        chk(busy == 1'b1 && int'(harm) == s, "R3 busy rises, harm holds start", longint'(harm), s);
        prev = s;
        for (int k = 1; k <= l; k++) begin
            @(negedge clk);
            if (dst >= s) chk(int'(harm) >= prev && int'(harm) <= dst, "R6 up monotonic", harm, prev);
            else          chk(int'(harm) <= prev && int'(harm) >= dst, "R6 down monotonic", harm, prev);
            if (k < l) chk(busy == 1'b1, "R3 busy width", busy, 1);
            prev = int'(harm);
        end
        chk(int'(harm) == dst && !busy, "R5 lands on destination", harm, dst);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(harm == 1 && !busy && phase == 0, "R1 reset state", harm, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(harm == 1 && !busy, "R1 first clock after reset", harm, 1);

        ramp(100, 50);                         // R2 upward
        rev_inc = 32'h0000_7FFF;
        ramp(20, 37);                          // downward with residue
        ramp(65535, 1000);                     // full-scale upward
        ramp(65535, 5);                        // zero slope
        ramp(3, 2);                            // minimum length, downward

        // R7 lengths 0 and 1
        wr(2'd0, 32'd900); wr(2'd1, 32'd0); wr(2'd2, 32'h1);
        chk(harm == 900 && !busy, "R7 length zero loads directly", harm, 900);
        wr(2'd0, 32'd40); wr(2'd1, 32'd1); wr(2'd2, 32'h1);
        chk(harm == 40 && !busy, "R7 length one loads directly", harm, 40);

        // R8 start while busy ignored; R10 writes while busy discarded
        wr(2'd0, 32'd240); wr(2'd1, 32'd30); wr(2'd2, 32'h1);
        repeat (5) @(negedge clk);
        wr(2'd2, 32'h1);
        wr(2'd0, 32'd7);
        wr(2'd1, 32'd0);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
        chk(harm == 240 && !busy, "R8 ramp end unchanged by extra start", harm, 240);
        wr(2'd0, 32'd240);
        wr(2'd1, 32'd0);
        wr(2'd0, 32'd500);
        wr(2'd2, 32'h1);
        chk(harm == 500, "R2 zero-length start after idle writes", harm, 500);
        // R10 re-check: ramp again, write during busy, then zero-length start reveals kept dest
        wr(2'd1, 32'd20); wr(2'd2, 32'h1);
        wr(2'd0, 32'd11);
        wr(2'd1, 32'd2);
        repeat (25) @(negedge clk);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h1);
        chk(harm == 500 && !busy, "R10 destination kept after busy write", harm, 500);

        // R1 mid-run reset
        wr(2'd0, 32'd3000); wr(2'd1, 32'd100); wr(2'd2, 32'h1);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(harm == 1 && !busy && phase == 0, "R1 reset during ramp", harm, 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule